// File: doc/BRIEF.md
# Attribute Index Generator

This block turns the 32-bit linear index of a dispatched thread into the element index used to fetch a vertex attribute. Threads are launched over a padded vertex count, so one linear index encodes both a vertex and an instance. The block can recover either part, or pass the index through unchanged. It applies one of four operations, selected per request: pass-through, remainder by an encoded constant, right shift, or division by an arbitrary constant. The division multiplies by a supplied reciprocal constant and can apply an optional round-down correction.

A request consists of the linear index, a 2-bit operation select, a 5-bit shift amount, a 3-bit flag field and a 32-bit multiplier constant. A request can be issued every cycle. The result appears exactly three clock edges later, with a valid bit that travels alongside it. The block does not derive any constants itself; software computes them and supplies them with each request.

Top module: `attr_index_gen`

## Requirements
- R1: With `in_mode` = 0 (pass-through), `out_idx` equals `in_id`.
- R2: With `in_mode` = 1 (remainder) and `in_flags` = f in 0..4, `out_idx` = `in_id` mod ((2f+1)·2^`in_shift`).
- R3: In remainder mode, flag values 5, 6 and 7 behave exactly like f = 4, giving a modulus of 9·2^`in_shift`.
- R4: With `in_mode` = 2 (shift divide), `out_idx` = `in_id` >> `in_shift`, for shifts 0 to 31.
- R5: With `in_mode` = 3 (reciprocal divide), the multiplier is `in_magic` with bit 31 forced to 1. The result is the upper 32 bits of the product of the operand and this multiplier, shifted right by `in_shift`. Bit 31 of `in_magic` has no effect.
- R6: In reciprocal divide mode, the operand is `in_id` + 1 when `in_flags` equals 1 and `in_id` otherwise. The operand is 33 bits wide, so `in_id` = 0xFFFFFFFF with the correction set does not wrap.
- R7: Constants are derived from a divisor d ≥ 1 as follows. Set s = floor(log2 d) and m = ceil(2^(s+32)/d). If 2^(s+32) mod d ≤ 2^s, use magic = m−1 with flags = 1; otherwise use magic = m with flags = 0. Reciprocal divide mode with these constants gives floor(`in_id`/d) for every `in_id`.
- R8: `out_valid` is high exactly three rising edges after a cycle with `in_valid` high and is low otherwise. Back-to-back requests return in order, one result per cycle.
- R9: While `rst_n` is low, `out_valid` and `out_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_id | input | 32 | Linear thread index |
| in_mode | input | 2 | 0 pass, 1 remainder, 2 shift divide, 3 reciprocal divide |
| in_shift | input | 5 | Shift amount / power-of-two exponent |
| in_flags | input | 3 | Odd factor selector (remainder) or round-down enable (divide) |
| in_magic | input | 32 | Reciprocal multiplier, bit 31 implied set |
| out_valid | output | 1 | Result present |
| out_idx | output | 32 | Attribute element index |

## Verification
The reciprocal divide is tested against true integer quotients. Random divisors are drawn from every magnitude, from 1 up to the full 32 bits. Those with a nonzero remainder at the threshold select the corrected path, and the others select the plain path. A wrong multiply word, a missing implied bit or a misplaced correction therefore shows up as an off-by-one quotient. Remainder requests sweep all eight flag codes and all shift amounts. This separates the odd-factor decode and the masking of the low bits, and the out-of-range codes are told apart from a wrapped factor. The stream mixes idle gaps with back-to-back requests, so a stage that drops or duplicates a request is caught, and so is a latency error.

// File: rtl/attr_idx_pkg.sv
package attr_idx_pkg;

  typedef enum logic [1:0] {
    AIG_PASS  = 2'd0,
    AIG_REM   = 2'd1,
    AIG_SHR   = 2'd2,
    AIG_RECIP = 2'd3
  } aig_mode_e;

  localparam int unsigned AIG_ID_W    = 32;
  localparam int unsigned AIG_SHIFT_W = 5;
  localparam int unsigned AIG_FLAG_W  = 3;
  localparam int unsigned AIG_STAGES  = 3;

endpackage

// File: rtl/attr_idx_rem_unit.sv
module attr_idx_rem_unit #(
  parameter int unsigned ID_W    = 32,
  parameter int unsigned SHIFT_W = 5,
  parameter int unsigned FLAG_W  = 3
) (
  input  logic [ID_W-1:0]    x,
  input  logic [SHIFT_W-1:0] sh,
  input  logic [FLAG_W-1:0]  fl,
  output logic [ID_W-1:0]    r
);

  // remainder of x by the odd factor picked by fl (1,3,5,7,9; codes above 4 give 9)
  function automatic logic [ID_W-1:0] odd_rem(input logic [ID_W-1:0] v,
                                               input logic [FLAG_W-1:0] f);
    case (f)
      FLAG_W'(0): odd_rem = '0;
      FLAG_W'(1): odd_rem = v % ID_W'(3);
      FLAG_W'(2): odd_rem = v % ID_W'(5);
      FLAG_W'(3): odd_rem = v % ID_W'(7);
      default:    odd_rem = v % ID_W'(9);
    endcase
  endfunction

  logic [ID_W-1:0] upper;
  logic [ID_W-1:0] low_mask;
  logic [ID_W-1:0] upper_rem;

  always_comb begin
    upper     = x >> sh;
    low_mask  = (ID_W'(1) << sh) - ID_W'(1);
    upper_rem = odd_rem(upper, fl);
    r         = (upper_rem << sh) | (x & low_mask);
  end

endmodule

// File: rtl/attr_idx_mul_unit.sv
module attr_idx_mul_unit #(
  parameter int unsigned ID_W   = 32,
  parameter int unsigned FLAG_W = 3
) (
  input  logic [ID_W-1:0]   id,
  input  logic [FLAG_W-1:0] fl,
  input  logic [ID_W-1:0]   magic,
  output logic              corr_en,
  output logic [ID_W-1:0]   hi
);

  localparam int unsigned OP_W   = ID_W + 1;
  localparam int unsigned PROD_W = 2 * ID_W + 1;

  function automatic logic [ID_W-1:0] mul_high(input logic [OP_W-1:0] op,
                                               input logic [ID_W-1:0] mult);
    logic [PROD_W-1:0] prod;
    prod     = PROD_W'(op) * PROD_W'(mult);
    mul_high = ID_W'(prod >> ID_W);
  endfunction

  logic [OP_W-1:0] operand;
  logic [ID_W-1:0] mult_eff;

  always_comb begin
    corr_en  = (fl == FLAG_W'(1));
    operand  = {1'b0, id} + OP_W'(corr_en);
    mult_eff = magic | (ID_W'(1) << (ID_W - 1));
    hi       = mul_high(operand, mult_eff);
  end

endmodule

// File: rtl/attr_index_gen.sv
module attr_index_gen
  import attr_idx_pkg::*;
#(
  parameter int unsigned ID_W    = AIG_ID_W,
  parameter int unsigned SHIFT_W = AIG_SHIFT_W,
  parameter int unsigned FLAG_W  = AIG_FLAG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [ID_W-1:0]    in_id,
  input  logic [1:0]         in_mode,
  input  logic [SHIFT_W-1:0] in_shift,
  input  logic [FLAG_W-1:0]  in_flags,
  input  logic [ID_W-1:0]    in_magic,
  output logic               out_valid,
  output logic [ID_W-1:0]    out_idx
);

  // stage 1: captured request
  logic               s1_valid;
  aig_mode_e          s1_mode;
  logic [ID_W-1:0]    s1_id;
  logic [SHIFT_W-1:0] s1_shift;
  logic [FLAG_W-1:0]  s1_flags;
  logic [ID_W-1:0]    s1_magic;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mode  <= AIG_PASS;
      s1_id    <= '0;
      s1_shift <= '0;
      s1_flags <= '0;
      s1_magic <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_mode  <= aig_mode_e'(in_mode);
      s1_id    <= in_id;
      s1_shift <= in_shift;
      s1_flags <= in_flags;
      s1_magic <= in_magic;
    end
  end

  // arithmetic between stage 1 and stage 2
  logic [ID_W-1:0] rem_val;
  logic [ID_W-1:0] mul_hi;
  logic            corr_en;

  attr_idx_rem_unit #(.ID_W(ID_W), .SHIFT_W(SHIFT_W), .FLAG_W(FLAG_W)) u_rem (
    .x  (s1_id),
    .sh (s1_shift),
    .fl (s1_flags),
    .r  (rem_val)
  );

  attr_idx_mul_unit #(.ID_W(ID_W), .FLAG_W(FLAG_W)) u_mul (
    .id      (s1_id),
    .fl      (s1_flags),
    .magic   (s1_magic),
    .corr_en (corr_en),
    .hi      (mul_hi)
  );

  // stage 2: operand for the final shift or select
  logic               s2_valid;
  aig_mode_e          s2_mode;
  logic [ID_W-1:0]    s2_val;
  logic [SHIFT_W-1:0] s2_shift;
  logic [ID_W-1:0]    s2_pick;

  always_comb begin
    case (s1_mode)
      AIG_REM:   s2_pick = rem_val;
      AIG_RECIP: s2_pick = mul_hi;
      default:   s2_pick = s1_id;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_mode  <= AIG_PASS;
      s2_val   <= '0;
      s2_shift <= '0;
    end else begin
      s2_valid <= s1_valid;
      s2_mode  <= s1_mode;
      s2_val   <= s2_pick;
      s2_shift <= s1_shift;
    end
  end

  // stage 3: post-shift for the divide modes, then output register
  logic            post_shift_en;
  logic [ID_W-1:0] s3_next;

  always_comb begin
    post_shift_en = (s2_mode == AIG_SHR) || (s2_mode == AIG_RECIP);
    s3_next       = post_shift_en ? (s2_val >> s2_shift) : s2_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
    end else begin
      out_valid <= s2_valid;
      out_idx   <= s3_next;
    end
  end

endmodule

// File: rtl/attr_index_gen_chk.sv
module attr_index_gen_chk #(
  parameter int unsigned ID_W    = 32,
  parameter int unsigned SHIFT_W = 5,
  parameter int unsigned FLAG_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [ID_W-1:0]    in_id,
  input logic [1:0]         in_mode,
  input logic [SHIFT_W-1:0] in_shift,
  input logic [FLAG_W-1:0]  in_flags,
  input logic               out_valid,
  input logic [ID_W-1:0]    out_idx
);

  localparam int unsigned D = 3;
  localparam int unsigned W2 = 2 * ID_W;

  logic               dv  [D];
  logic [ID_W-1:0]    did [D];
  logic [1:0]         dmd [D];
  logic [SHIFT_W-1:0] dsh [D];
  logic [FLAG_W-1:0]  dfl [D];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < D; i++) begin
        dv[i] <= 1'b0; did[i] <= '0; dmd[i] <= '0; dsh[i] <= '0; dfl[i] <= '0;
      end
    end else begin
      dv[0] <= in_valid; did[0] <= in_id; dmd[0] <= in_mode;
      dsh[0] <= in_shift; dfl[0] <= in_flags;
      for (int i = 1; i < D; i++) begin
        dv[i] <= dv[i-1]; did[i] <= did[i-1]; dmd[i] <= dmd[i-1];
        dsh[i] <= dsh[i-1]; dfl[i] <= dfl[i-1];
      end
    end
  end

  logic [W2-1:0] rem_bound;
  always_comb begin
    rem_bound = W2'((dfl[D-1] > FLAG_W'(4)) ? 9 : (2 * int'(dfl[D-1]) + 1)) << dsh[D-1];
  end

  // R8
  latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == dv[D-1]);

  // R1
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dmd[D-1] == 2'd0) |-> out_idx == did[D-1]);

  // R2
  rem_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dmd[D-1] == 2'd1) |-> W2'(out_idx) < rem_bound);

  // R4
  shift_divide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dmd[D-1] == 2'd2) |-> out_idx == (did[D-1] >> dsh[D-1]));

  // R6
  recip_no_overshoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dmd[D-1] == 2'd3) |-> out_idx <= (did[D-1] >> dsh[D-1]));

  // R9
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (out_valid == 1'b0 && out_idx == '0);
    end
  end

endmodule

bind attr_index_gen attr_index_gen_chk #(.ID_W(ID_W), .SHIFT_W(SHIFT_W), .FLAG_W(FLAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_id     (in_id),
  .in_mode   (in_mode),
  .in_shift  (in_shift),
  .in_flags  (in_flags),
  .out_valid (out_valid),
  .out_idx   (out_idx)
);

// File: tb/attr_index_gen_test.sv
module attr_index_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_id = '0;
  logic [1:0]  in_mode = '0;
  logic [4:0]  in_shift = '0;
  logic [2:0]  in_flags = '0;
  logic [31:0] in_magic = '0;
  logic        out_valid;
  logic [31:0] out_idx;

  always #4 clk = ~clk;

  attr_index_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id),
    .in_mode(in_mode), .in_shift(in_shift), .in_flags(in_flags),
    .in_magic(in_magic), .out_valid(out_valid), .out_idx(out_idx)
  );

  typedef struct {
    logic [31:0] val;
    int          due;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, expv);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [31:0] ref_rem(input logic [31:0] id, input int sh, input int fl);
    longint unsigned k, modulus;
    k = (fl > 4) ? 9 : 2 * fl + 1;
    modulus = k * (64'd1 << sh);
    return 32'(64'(id) % modulus);
  endfunction

  function automatic logic [31:0] ref_recip(input logic [31:0] id, input int sh,
                                            input int fl, input logic [31:0] mg);
    longint unsigned mult, op, prod;
    mult = 64'(mg[30:0]) + 64'h8000_0000;
    op   = 64'(id) + ((fl == 1) ? 64'd1 : 64'd0);
    prod = op * mult;
    return 32'((prod >> 32) >> sh);
  endfunction

  function automatic logic [31:0] ref_any(input logic [31:0] id, input logic [1:0] md,
                                          input int sh, input int fl, input logic [31:0] mg);
    case (md)
      2'd0:    return id;
      2'd1:    return ref_rem(id, sh, fl);
      2'd2:    return id >> sh;
      default: return ref_recip(id, sh, fl, mg);
    endcase
  endfunction

  task automatic make_consts(input logic [31:0] d, output logic [4:0] sh,
                             output logic [2:0] fl, output logic [31:0] mg);
    int s;
    longint unsigned num, m, e;
    s = 0;
    for (int b = 0; b < 32; b++) if (d[b]) s = b;
    num = 64'd1 << (s + 32);
    m = (num + 64'(d) - 1) / 64'(d);
    e = num % 64'(d);
    sh = 5'(s);
    if (e <= (64'd1 << s)) begin mg = 32'(m - 1); fl = 3'd1; end
    else begin mg = 32'(m); fl = 3'd0; end
  endtask

  // ---------------- driver and monitor ----------------
  task automatic send(input logic [31:0] id, input logic [1:0] md, input logic [4:0] sh,
                      input logic [2:0] fl, input logic [31:0] mg,
                      input logic [31:0] expv, input string tag);
    exp_t e;
    in_valid = 1'b1; in_id = id; in_mode = md; in_shift = sh; in_flags = fl; in_magic = mg;
    e.val = expv; e.due = cyc + 3; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        check(out_valid === 1'b1, {exp_q[0].tag, " R8 valid"}, 32'(out_valid), 32'd1);
        check(out_idx === exp_q[0].val, exp_q[0].tag, out_idx, exp_q[0].val);
        void'(exp_q.pop_front());
      end else if (out_valid !== 1'b0) begin
        check(1'b0, "R8 unexpected valid", 32'(out_valid), 32'd0);
      end
    end
  end

  function automatic string tag_of(input logic [1:0] md);
    case (md)
      2'd0:    return "R1";
      2'd1:    return "R2";
      2'd2:    return "R4";
      default: return "R5";
    endcase
  endfunction

  // ---------------- stimulus ----------------
  initial begin
    logic [4:0]  sh;
    logic [2:0]  fl;
    logic [31:0] mg, d, id;
    logic [1:0]  md;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_idx === 32'd0, "R9 reset state",
          {31'd0, out_valid} | out_idx, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    send(32'hDEAD_BEEF, 2'd0, 5'd7, 3'd2, 32'h1234_5678, 32'hDEAD_BEEF, "R1");
    send(32'd70, 2'd1, 5'd3, 3'd4, 32'd0, 32'd70 % 32'd72, "R2");
    send(32'd1000, 2'd1, 5'd2, 3'd0, 32'd0, 32'd0, "R2");
    for (int f = 5; f < 8; f++)
      send(32'hFFFF_FFF0, 2'd1, 5'd4, 3'(f), 32'd0, ref_rem(32'hFFFF_FFF0, 4, 4), "R3");
    send(32'h8000_0000, 2'd2, 5'd31, 3'd0, 32'd0, 32'd1, "R4");
    send(32'h1234_5678, 2'd2, 5'd0, 3'd0, 32'd0, 32'h1234_5678, "R4");
    send(32'd600, 2'd3, 5'd0, 3'd0, 32'h0000_0000, ref_recip(32'd600, 0, 0, 32'h8000_0000), "R5");
    send(32'd600, 2'd3, 5'd0, 3'd0, 32'h8000_0000, ref_recip(32'd600, 0, 0, 32'h8000_0000), "R5");
    send(32'hFFFF_FFFF, 2'd3, 5'd0, 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6");
    send(32'hFFFF_FFFF, 2'd3, 5'd0, 3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFE, "R6");
    make_consts(32'd7, sh, fl, mg);
    send(32'hFFFF_FFFF, 2'd3, sh, fl, mg, 32'hFFFF_FFFF / 32'd7, "R7");
    make_consts(32'd72, sh, fl, mg);
    send(32'd143, 2'd3, sh, fl, mg, 32'd1, "R7");
    idle(5);
    check(out_valid === 1'b0, "R8 idle after gap", 32'(out_valid), 32'd0);

    // random mixed modes, back-to-back with occasional gaps
    for (int n = 0; n < 3000; n++) begin
      md = 2'($urandom_range(0, 3));
      sh = 5'($urandom_range(0, 31));
      fl = 3'($urandom_range(0, 7));
      mg = $urandom;
      id = $urandom;
      if (n % 50 == 0) id = 32'hFFFF_FFFF;
      send(id, md, sh, fl, mg, ref_any(id, md, int'(sh), int'(fl), mg), tag_of(md));
      if ($urandom_range(0, 9) == 0) idle($urandom_range(1, 4));
    end

    // reciprocal divide against true quotient
    for (int n = 0; n < 3000; n++) begin
      d = $urandom >> $urandom_range(0, 31);
      if (d == 32'd0) d = 32'd1;
      id = (n % 97 == 0) ? 32'hFFFF_FFFF : $urandom;
      make_consts(d, sh, fl, mg);
      send(id, 2'd3, sh, fl, mg, id / d, "R7");
    end

    idle(6);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule